// File: doc/BRIEF.md
# Iterative Unsigned Multiply/Divide Unit

This block is the arithmetic helper next to the datapath of a small 8-bit processor core. It performs unsigned multiplication and unsigned division in a short form and a long form. The short form is 16 bits by 8 bits and the long form is 24 bits by 16 bits. The core presents both operands and a 2-bit operation code with a single-cycle start strobe. The unit then raises busy for a latency that is fixed for each of the four operations and independent of the operand values.

On the last busy cycle a one-cycle done strobe marks the result as valid. The product or quotient appears on a 40-bit result bus. The remainder appears on a 16-bit bus. A flag reports a zero divisor. These outputs stay frozen after completion until the core starts the next operation, so the core may collect them at its own pace. Internally, the multiplier retires two multiplier bits per cycle. The divider retires two quotient bits per cycle with a pair of chained restoring stages.

Top module: `mdu_core`

## Requirements
- R1: `op_i` selects the operation: 2'b00 short multiply, 2'b01 long multiply, 2'b10 short divide, 2'b11 long divide. Short forms use only `opa_i[15:0]` and `opb_i[7:0]`, and the upper operand bits have no effect on any output.
- R2: A start is accepted on a rising edge where `start_i` is high and `busy_o` is low. From the next cycle, `busy_o` stays high for exactly 5 cycles for a short multiply, 12 for a long multiply, 8 for a short divide and 12 for a long divide. It is then low.
- R3: `done_o` is high for exactly one cycle, the last cycle in which `busy_o` is high, and is low at all other times.
- R4: In the done cycle of a multiply, `result_o` holds the full unsigned product (24 significant bits for short, 40 for long), `rem_o` is 0 and `div0_o` is 0.
- R5: In the done cycle of a divide with a nonzero divisor, `result_o` holds the unsigned quotient zero-extended to 40 bits, `rem_o` holds the remainder zero-extended to 16 bits, and `div0_o` is 0.
- R6: A divide with a zero divisor sets `div0_o`. The quotient is all ones at the quotient width of the form (16'hFFFF short, 24'hFFFFFF long), and `rem_o` carries the low 16 bits of the dividend. The latency is unchanged.
- R7: `start_i` has no effect while `busy_o` is high, including in the done cycle. It does not alter the latency, the results or the operation in flight, whatever the operands and code driven with it.
- R8: After the done cycle, `result_o`, `rem_o` and `div0_o` keep their values until the next accepted start.
- R9: After reset, `busy_o`, `done_o`, `div0_o`, `result_o` and `rem_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled with the operands and code |
| op_i | input | 2 | Operation code (see R1) |
| opa_i | input | 24 | Multiplicand or dividend |
| opb_i | input | 16 | Multiplier or divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion strobe, results valid |
| result_o | output | 40 | Product or zero-extended quotient |
| rem_o | output | 16 | Remainder (0 for multiply) |
| div0_o | output | 1 | Last divide had a zero divisor |

## Verification
Some properties are checked on every cycle. These are the countdown of the busy window, the single-cycle done strobe followed by idle, the operation staying frozen while a start is refused, and output stability while idle. They also cover the divider's partial remainder staying below a nonzero divisor, the multiplier accumulator freezing once the multiplier bits are exhausted, and an all-ones quotient whenever the zero-divisor flag is set at completion. Arithmetic correctness can only be shown by the bench's scenarios. The bench sweeps every 8-bit divisor and multiplier against a set of short operands carrying garbage upper bits, and runs pseudo-random long operands. It also shows the exact per-operation latency, and that a start held high throughout a busy window changes nothing.

// File: rtl/mdu_pkg.sv
`timescale 1ns/1ps
// mdu_pkg: shared operation encoding for the multiply/divide unit.
// Assumes bit 1 of the code selects divide and bit 0 selects the long form.
package mdu_pkg;

    typedef enum logic [1:0] {
        OP_MUL_S = 2'b00,
        OP_MUL_L = 2'b01,
        OP_DIV_S = 2'b10,
        OP_DIV_L = 2'b11
    } mdu_op_e;

    function automatic logic op_is_div(input mdu_op_e op);
        return op[1];
    endfunction

    function automatic logic op_is_long(input mdu_op_e op);
        return op[0];
    endfunction

endpackage

// File: rtl/mdu_ctrl.sv
`timescale 1ns/1ps
// mdu_ctrl: sequences one operation. It accepts a start only when idle,
// loads a per-operation countdown, and produces the load/step strobes for
// the datapaths together with busy and done.
// Assumes each latency parameter is at least 1 and at most LAT_MAX.
module mdu_ctrl
    import mdu_pkg::*;
#(
    parameter int LAT_MS = 5,
    parameter int LAT_ML = 12,
    parameter int LAT_DS = 8,
    parameter int LAT_DL = 12
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start_i,
    input  mdu_op_e op_i,
    output logic    load_o,
    output logic    step_o,
    output mdu_op_e op_act_o,
    output mdu_op_e op_q_o,
    output logic    busy_o,
    output logic    done_o
);
    localparam int LAT_A   = (LAT_MS > LAT_ML) ? LAT_MS : LAT_ML;
    localparam int LAT_B   = (LAT_DS > LAT_DL) ? LAT_DS : LAT_DL;
    localparam int LAT_MAX = (LAT_A > LAT_B) ? LAT_A : LAT_B;
    localparam int CNT_W   = (LAT_MAX > 2) ? $clog2(LAT_MAX) : 1;

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    mdu_op_e          op_q;

    function automatic int lat_of(input mdu_op_e op);
        case (op)
            OP_MUL_S: return LAT_MS;
            OP_MUL_L: return LAT_ML;
            OP_DIV_S: return LAT_DS;
            default:  return LAT_DL;
        endcase
    endfunction

    // Accept a new operation only while idle.
    assign load_o   = start_i & ~busy_q;
    // Datapath advances on the load edge and every busy edge except the last.
    assign step_o   = load_o | (busy_q & (cnt_q != '0));
    assign op_act_o = load_o ? op_i : op_q;
    assign op_q_o   = op_q;
    assign busy_o   = busy_q;
    assign done_o   = busy_q & (cnt_q == '0);

    // Countdown and operation register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            op_q   <= OP_MUL_S;
        end else if (load_o) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(lat_of(op_i) - 1);
            op_q   <= op_i;
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    // R2
    lat_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> (cnt_q == CNT_W'(lat_of(op_q) - 1)));
    // R2
    busy_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));
    // R3
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!busy_o && !done_o));
    // R7
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start_i) |=> $stable(op_q));

endmodule

// File: rtl/mdu_mul.sv
`timescale 1ns/1ps
// mdu_mul: shift-add multiplier retiring BITS multiplier bits per step.
// Assumes operands arrive already masked to the active form. Extra steps
// after the multiplier is exhausted leave the product unchanged.
module mdu_mul #(
    parameter int A_W  = 24,
    parameter int B_W  = 16,
    parameter int BITS = 2,
    localparam int P_W = A_W + B_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic           step_i,
    input  logic [A_W-1:0] a_i,
    input  logic [B_W-1:0] b_i,
    output logic [P_W-1:0] prod_o
);
    logic [P_W-1:0] acc_q, mc_q;
    logic [B_W-1:0] mp_q;

    logic [P_W-1:0] acc_c [0:BITS];
    logic [P_W-1:0] mc_c  [0:BITS];
    logic [B_W-1:0] mp_c  [0:BITS];

    // Chain input: fresh operands on load, otherwise the stored state.
    assign acc_c[0] = load_i ? '0 : acc_q;
    assign mc_c[0]  = load_i ? P_W'(a_i) : mc_q;
    assign mp_c[0]  = load_i ? b_i : mp_q;

    // One conditional add per retired multiplier bit.
    for (genvar g = 0; g < BITS; g++) begin : g_bit
        assign acc_c[g+1] = acc_c[g] + (mp_c[g][0] ? mc_c[g] : '0);
        assign mc_c[g+1]  = mc_c[g] << 1;
        assign mp_c[g+1]  = mp_c[g] >> 1;
    end

    // State update on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            mc_q  <= '0;
            mp_q  <= '0;
        end else if (step_i) begin
            acc_q <= acc_c[BITS];
            mc_q  <= mc_c[BITS];
            mp_q  <= mp_c[BITS];
        end
    end

    assign prod_o = acc_q;

    // R4
    mul_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && mp_q == '0) |=> $stable(acc_q));

endmodule

// File: rtl/mdu_div.sv
`timescale 1ns/1ps
// mdu_div: restoring divider producing BITS quotient bits per step.
// Assumes the dividend is left-aligned in N_W bits. For a zero divisor every
// quotient bit is 1 and the dividend bits collect in the remainder register.
module mdu_div #(
    parameter int N_W  = 24,
    parameter int D_W  = 16,
    parameter int BITS = 2,
    localparam int R_W = D_W + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic           step_i,
    input  logic [N_W-1:0] dvd_i,
    input  logic [D_W-1:0] dvs_i,
    output logic [N_W-1:0] quo_o,
    output logic [D_W-1:0] rem_o
);
    logic [N_W-1:0] q_q;
    logic [R_W-1:0] r_q;
    logic [D_W-1:0] d_q;

    logic [D_W-1:0] d_cur;
    logic [R_W-1:0] d_ext;
    logic [N_W-1:0] q_c [0:BITS];
    logic [R_W-1:0] r_c [0:BITS];

    // Chain input: fresh operands on load, otherwise the stored state.
    assign d_cur  = load_i ? dvs_i : d_q;
    assign d_ext  = {1'b0, d_cur};
    assign q_c[0] = load_i ? dvd_i : q_q;
    assign r_c[0] = load_i ? '0 : r_q;

    // One shift/compare/subtract stage per quotient bit.
    for (genvar g = 0; g < BITS; g++) begin : g_stage
        logic [R_W-1:0] trial;
        logic           fits;
        assign trial      = {r_c[g][D_W-1:0], q_c[g][N_W-1]};
        assign fits       = (trial >= d_ext);
        assign r_c[g+1]   = fits ? (trial - d_ext) : trial;
        assign q_c[g+1]   = {q_c[g][N_W-2:0], fits};
    end

    // State update on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '0;
            r_q <= '0;
            d_q <= '0;
        end else if (step_i) begin
            q_q <= q_c[BITS];
            r_q <= r_c[BITS];
            d_q <= d_cur;
        end
    end

    assign quo_o = q_q;
    assign rem_o = r_q[D_W-1:0];

    // R5
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (d_q != '0) |-> (r_q < {1'b0, d_q}));

endmodule

// File: rtl/mdu_core.sv
`timescale 1ns/1ps
// mdu_core: unsigned multiply/divide unit with a fixed latency per operation.
// Masks the operands for the short forms, routes them to the multiplier or
// divider, and selects the outputs by the operation in flight.
// Assumes LAT_DS*DIV_BITS == AS_W and LAT_DL*DIV_BITS == A_W, and that each
// multiply latency covers its multiplier width at MUL_BITS bits per cycle.
module mdu_core
    import mdu_pkg::*;
#(
    parameter int A_W      = 24,
    parameter int B_W      = 16,
    parameter int AS_W     = 16,
    parameter int BS_W     = 8,
    parameter int MUL_BITS = 2,
    parameter int DIV_BITS = 2,
    parameter int LAT_MS   = 5,
    parameter int LAT_ML   = 12,
    parameter int LAT_DS   = 8,
    parameter int LAT_DL   = 12,
    localparam int P_W     = A_W + B_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [1:0]     op_i,
    input  logic [A_W-1:0] opa_i,
    input  logic [B_W-1:0] opb_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [P_W-1:0] result_o,
    output logic [B_W-1:0] rem_o,
    output logic           div0_o
);
    localparam int PAD_W = A_W - AS_W;

    mdu_op_e        op_in, op_act, op_q;
    logic           load, step;
    logic           short_in;
    logic [A_W-1:0] a_mask, dvd_al;
    logic [B_W-1:0] b_mask;
    logic [P_W-1:0] prod;
    logic [A_W-1:0] quo;
    logic [B_W-1:0] rem;
    logic           div0_q;

    assign op_in    = mdu_op_e'(op_i);
    assign short_in = ~op_is_long(op_in);

    // Operand masking and alignment for the short forms.
    assign a_mask = short_in ? A_W'(opa_i[AS_W-1:0]) : opa_i;
    assign b_mask = short_in ? B_W'(opb_i[BS_W-1:0]) : opb_i;
    assign dvd_al = short_in ? {opa_i[AS_W-1:0], {PAD_W{1'b0}}} : opa_i;

    mdu_ctrl #(
        .LAT_MS(LAT_MS), .LAT_ML(LAT_ML), .LAT_DS(LAT_DS), .LAT_DL(LAT_DL)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_in),
        .load_o(load), .step_o(step), .op_act_o(op_act), .op_q_o(op_q),
        .busy_o(busy_o), .done_o(done_o)
    );

    mdu_mul #(.A_W(A_W), .B_W(B_W), .BITS(MUL_BITS)) u_mul (
        .clk(clk), .rst_n(rst_n),
        .load_i(load & ~op_is_div(op_in)),
        .step_i(step & ~op_is_div(op_act)),
        .a_i(a_mask), .b_i(b_mask), .prod_o(prod)
    );

    mdu_div #(.N_W(A_W), .D_W(B_W), .BITS(DIV_BITS)) u_div (
        .clk(clk), .rst_n(rst_n),
        .load_i(load & op_is_div(op_in)),
        .step_i(step & op_is_div(op_act)),
        .dvd_i(dvd_al), .dvs_i(b_mask), .quo_o(quo), .rem_o(rem)
    );

    // Zero-divisor flag captured with the operands.
    always_ff @(posedge clk) begin
        if (!rst_n)    div0_q <= 1'b0;
        else if (load) div0_q <= op_is_div(op_in) & (b_mask == '0);
    end

    // Output selection by the operation in flight.
    always_comb begin
        if (!op_is_div(op_q)) begin
            result_o = prod;
            rem_o    = '0;
        end else begin
            result_o = op_is_long(op_q) ? P_W'(quo) : P_W'(quo[AS_W-1:0]);
            rem_o    = rem;
        end
    end
    assign div0_o = div0_q;

    // R6
    div0_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && div0_o) |-> (op_is_long(op_q) ? (result_o == P_W'({A_W{1'b1}}))
                                                 : (result_o == P_W'({AS_W{1'b1}}))));
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(result_o) && $stable(rem_o) && $stable(div0_o)));

endmodule

// File: tb/tb_mdu_core.sv
`timescale 1ns/1ps
module tb_mdu_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic [23:0] opa_i = '0;
    logic [15:0] opb_i = '0;
    logic        busy_o, done_o, div0_o;
    logic [39:0] result_o;
    logic [15:0] rem_o;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    always #4 clk = ~clk;

    mdu_core dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o), .done_o(done_o),
        .result_o(result_o), .rem_o(rem_o), .div0_o(div0_o)
    );

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x = s;
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        return x;
    endfunction

    task automatic check(input bit ok, input string req, input logic [39:0] act,
                         input logic [39:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs one operation; inject holds start high with other operands while busy.
    task automatic run_op(input logic [1:0] op, input logic [23:0] a, input logic [15:0] b,
                          input bit inject, input bit hold);
        int n;
        logic [23:0] ea;
        logic [15:0] eb;
        logic [39:0] eres;
        logic [15:0] erem;
        logic        edz;
        bit          lat_ok;
        case (op)
            2'b00: n = 5;
            2'b01: n = 12;
            2'b10: n = 8;
            default: n = 12;
        endcase
        ea = op[0] ? a : {8'h0, a[15:0]};
        eb = op[0] ? b : {8'h0, b[7:0]};
        edz = 1'b0; erem = '0;
        if (!op[1]) eres = 40'(ea) * 40'(eb);
        else if (eb == 0) begin
            edz = 1'b1; erem = a[15:0];
            eres = op[0] ? 40'hFF_FFFF : 40'hFFFF;
        end else begin
            eres = 40'(ea / 24'(eb)); erem = 16'(ea % 24'(eb));
        end
        @(negedge clk);
        start_i = 1'b1; op_i = op; opa_i = a; opb_i = b;
        @(negedge clk);
        start_i = 1'b0;
        lat_ok = 1'b1;
        for (int i = 1; i <= n; i++) begin
            if (i > 1) @(negedge clk);
            if (!busy_o || (done_o != (i == n))) lat_ok = 1'b0;
            if (inject && i == 1) begin
                start_i = 1'b1; op_i = ~op; opa_i = ~a; opb_i = ~b;
            end
            if (i == n) begin
                // R4 / R5 / R6 result, remainder and flag in the done cycle
                check(result_o == eres, op[1] ? "R5/R6 quotient" : "R4 product", result_o, eres);
                check(rem_o == erem, op[1] ? "R5/R6 remainder" : "R4 remainder", 40'(rem_o), 40'(erem));
                check(div0_o == edz, "R6 div0 flag", 40'(div0_o), 40'(edz));
            end
        end
        @(negedge clk);
        start_i = 1'b0;
        if (busy_o || done_o) lat_ok = 1'b0;
        // R2 / R3 latency window (R7 when injected)
        check(lat_ok, inject ? "R7 busy-start latency" : "R2/R3 latency", 40'(lat_ok), 40'd1);
        if (hold) begin
            repeat (3) @(negedge clk);
            // R8 outputs held while idle
            check(result_o == eres && rem_o == erem && div0_o == edz && !done_o,
                  "R8 hold", result_o, eres);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check(!busy_o && !done_o && !div0_o && result_o == '0 && rem_o == '0,
              "R9 reset", result_o, 40'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Short multiply sweep, upper bits garbage (R1, R4)
        for (int k = 0; k < 8; k++) begin
            logic [23:0] a;
            case (k)
                0: a = 24'h00_0000; 1: a = 24'hAB_0001; 2: a = 24'hFF_FFFF;
                3: a = 24'h5A_1234; default: begin seed = nxt(seed); a = seed[23:0]; end
            endcase
            for (int b = 0; b < 256; b++)
                run_op(2'b00, a, {8'hC3, 8'(b)}, 1'b0, 1'b0);
        end
        // Short divide sweep over every divisor, including zero (R1, R5, R6)
        for (int k = 0; k < 8; k++) begin
            logic [23:0] a;
            case (k)
                0: a = 24'h00_0000; 1: a = 24'h7E_0001; 2: a = 24'hFF_FFFF;
                3: a = 24'h33_00FF; default: begin seed = nxt(seed); a = seed[23:0]; end
            endcase
            for (int b = 0; b < 256; b++)
                run_op(2'b10, a, {8'h9D, 8'(b)}, 1'b0, 1'b0);
        end
        // Long forms, pseudo-random and corners (R4, R5)
        for (int k = 0; k < 400; k++) begin
            logic [23:0] a;
            logic [15:0] b;
            seed = nxt(seed); a = seed[23:0];
            seed = nxt(seed); b = seed[15:0];
            if (k % 5 == 0) b = b >> (k % 16);
            if (b == 0) b = 16'd1;
            run_op(2'b01, a, b, 1'b0, 1'b0);
            run_op(2'b11, a, b, 1'b0, 1'b0);
        end
        run_op(2'b01, 24'hFF_FFFF, 16'hFFFF, 1'b0, 1'b1);
        run_op(2'b11, 24'hFF_FFFF, 16'hFFFF, 1'b0, 1'b1);
        run_op(2'b11, 24'hFF_FFFF, 16'h0001, 1'b0, 1'b1);
        run_op(2'b11, 24'h00_0005, 16'h0007, 1'b0, 1'b1);
        // Long divide by zero (R6)
        run_op(2'b11, 24'hA5_C3E1, 16'h0000, 1'b0, 1'b1);
        run_op(2'b10, 24'h00_BEEF, 16'h0000, 1'b0, 1'b1);
        // Start held high while busy for each form (R7), then hold (R8)
        run_op(2'b00, 24'h00_F00D, 16'h00A7, 1'b1, 1'b1);
        run_op(2'b01, 24'h12_3456, 16'h789A, 1'b1, 1'b1);
        run_op(2'b10, 24'h00_FFFE, 16'h0003, 1'b1, 1'b1);
        run_op(2'b11, 24'h98_7654, 16'h0321, 1'b1, 1'b1);

        ended = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!ended) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule